// File: doc/BRIEF.md
# Saturating Branch Sample Buffer

This block captures pairs of branch source and destination addresses into a small register file while sampling is switched on. Each retired-branch strobe stores its 64-bit source and 64-bit destination at the slot named by a next-slot pointer, and the pointer then advances. The buffer fills in one pass and never overwrites itself. When the final slot is written, the block clears its own enable bit, returns the pointer to zero and raises a level interrupt, so the newest entry sits just below the pointer, with wrap-around.

Software reaches the block through a simple register port. One control/status word holds the enable bit, the valid flag, the next-slot pointer and a 3-bit field that names the counter behind the sampling event. The entry registers are interleaved: for slot i, the source address is at address 2*i and the destination at 2*i+1. Software may overwrite any entry. This lets it plant a marker value that shows where the valid data ends. No branch filtering of any kind is applied.

Top module: `brsamp_buf`

## Requirements
- R1: After reset the control word (address 32) reads 0x18, with bits [4:3] at binary 11 and every other bit 0, and irq is low. Bits [4:3] always read 11, and reserved bits always read 0.
- R2: Read data appears on reg_rdata on the cycle after reg_rd is sampled and is held until the next read. In the control word, bit 2 is enable, bit 5 is the valid flag, bits [19:16] are the next-slot pointer and bits [26:24] are the counter select. A control write loads all four fields from the written data.
- R3: Address 2*i returns the source address of slot i and address 2*i+1 returns its destination address, for i from 0 to 15.
- R4: While enable is 1, a branch strobe stores its source and destination at the slot given by the pointer, increments the pointer and sets the valid flag.
- R5: Recording into slot 15 sets the pointer to 0, clears enable and raises irq in the same cycle.
- R6: A branch strobe while enable is 0 changes no entry, no pointer and no flag.
- R7: Once raised, irq stays high until the control word is written, and any control write clears it.
- R8: A software write to an entry register stores the 64-bit value unchanged. This includes the marker 0xFFFFFFFFFFFFFFFE.
- R9: Writing back the control word with only enable cleared keeps the pointer and the valid flag. Writing zero sets the pointer to 0 and clears the valid flag.
- R10: When a control write and a branch strobe arrive in the same cycle, the control write takes effect and the branch is dropped. When an entry write and a recorded branch arrive in the same cycle, the branch is stored and the entry write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Retired taken-branch strobe |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch destination address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address (0..31 entries, 32 control) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after reg_rd |
| irq | output | 1 | Level interrupt, buffer full |

## Verification
The bench fills all sixteen slots and then checks the pointer wrap, the self-clear of enable and the interrupt level. A design that wraps one slot early or late, or keeps recording, would overwrite slot 0, and the bench reads that slot back to catch it. Strobes sent while disabled and after saturation must leave every entry and the control word as they were, so a missing enable gate shows up as a changed pointer or a changed entry. The bench also drives same-cycle collisions between a control write and a branch, and between an entry write and a branch, to expose wrong priority. Read-modify-write of the enable bit, the zero-write reset of the pointer and valid flag, and the marker write catch field misplacement and pointer loss.

// File: rtl/brsamp_pkg.sv
package brsamp_pkg;
  localparam int DATA_W   = 64;
  localparam int EN_BIT   = 2;
  localparam int FIX_LSB  = 3;
  localparam int VB_BIT   = 5;
  localparam int PTR_LSB  = 16;
  localparam int PTR_W    = 4;
  localparam int SEL_LSB  = 24;
  localparam int SEL_W    = 3;
  localparam logic [1:0] FIX_VAL = 2'b11;

  typedef struct packed {
    logic             en;
    logic             vb;
    logic [PTR_W-1:0] ptr;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[FIX_LSB +: 2] = FIX_VAL;
    w[VB_BIT] = c.vb;
    w[PTR_LSB +: PTR_W] = c.ptr;
    w[SEL_LSB +: SEL_W] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/brsamp_ctrl.sv
module brsamp_ctrl
  import brsamp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic              rec,
  output logic [IW-1:0]     rec_idx,
  output logic [DATA_W-1:0] ctl_word,
  output logic              irq
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic          en_q;
  logic          vb_q;
  logic [IW-1:0] ptr_q;
  logic [SEL_W-1:0] sel_q;
  logic          irq_q;
  ctl_t          view;

  assign rec     = br_valid & en_q & ~ctl_wr;
  assign rec_idx = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      vb_q  <= 1'b0;
      ptr_q <= '0;
      sel_q <= '0;
      irq_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q  <= ctl_wdata[EN_BIT];
      vb_q  <= ctl_wdata[VB_BIT];
      ptr_q <= ctl_wdata[PTR_LSB +: IW];
      sel_q <= ctl_wdata[SEL_LSB +: SEL_W];
      irq_q <= 1'b0;
    end else if (rec) begin
      vb_q <= 1'b1;
      if (ptr_q == LAST) begin
        ptr_q <= '0;
        en_q  <= 1'b0;
        irq_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_comb begin
    view     = '0;
    view.en  = en_q;
    view.vb  = vb_q;
    view.ptr = PTR_W'(ptr_q);
    view.sel = sel_q;
    ctl_word = pack_ctl(view);
  end

  assign irq = irq_q;
endmodule

// File: rtl/brsamp_mem.sv
module brsamp_mem #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/brsamp_buf.sv
module brsamp_buf
  import brsamp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [DATA_W-1:0] br_from,
  input  logic [DATA_W-1:0] br_to,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(2 * DEPTH);

  logic              is_ctl, is_ent, ctl_wr, ent_wr;
  logic              rec;
  logic [IW-1:0]     rec_idx;
  logic [DATA_W-1:0] ctl_word;
  logic [IW-1:0]     ent_idx;
  logic              ent_lane;
  logic [DATA_W-1:0] lane_q [2];
  logic [DATA_W-1:0] ctl_q;
  logic              sel_ctl_q, sel_ent_q, sel_lane_q;

  assign is_ctl   = (reg_addr == CTL_ADDR);
  assign is_ent   = ~reg_addr[AW-1];
  assign ctl_wr   = reg_wr & is_ctl;
  assign ent_wr   = reg_wr & is_ent & ~rec;
  assign ent_idx  = reg_addr[IW:1];
  assign ent_lane = reg_addr[0];

  brsamp_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .br_valid(br_valid), .ctl_wr(ctl_wr),
    .ctl_wdata(reg_wdata), .rec(rec), .rec_idx(rec_idx),
    .ctl_word(ctl_word), .irq(irq)
  );

  // lane 0 holds source addresses, lane 1 destination addresses
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic              we;
    logic [IW-1:0]     waddr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] brd;
    assign brd   = (g == 0) ? br_from : br_to;
    assign we    = rec | (ent_wr & (ent_lane == 1'(g)));
    assign waddr = rec ? rec_idx : ent_idx;
    assign wdata = rec ? brd : reg_wdata;
    brsamp_mem #(.WIDTH(DATA_W), .DEPTH(DEPTH)) mem_i (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .re(reg_rd), .raddr(ent_idx), .rdata(lane_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      sel_ctl_q  <= 1'b0;
      sel_ent_q  <= 1'b0;
      sel_lane_q <= 1'b0;
    end else if (reg_rd) begin
      ctl_q      <= ctl_word;
      sel_ctl_q  <= is_ctl;
      sel_ent_q  <= is_ent;
      sel_lane_q <= ent_lane;
    end
  end

  always_comb begin
    if (sel_ctl_q)      reg_rdata = ctl_q;
    else if (sel_ent_q) reg_rdata = sel_lane_q ? lane_q[1] : lane_q[0];
    else                reg_rdata = '0;
  end
endmodule

// File: rtl/brsamp_chk.sv
module brsamp_chk
  import brsamp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              br_valid,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [AW-1:0]     reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] ctl_word
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(2 * DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic          cwr, en, vb, hit;
  logic [IW-1:0] ptr;
  assign cwr = reg_wr & (reg_addr == CTL_ADDR);
  assign en  = ctl_word[EN_BIT];
  assign vb  = ctl_word[VB_BIT];
  assign ptr = ctl_word[PTR_LSB +: IW];
  assign hit = br_valid & en & ~cwr;

  AST_CTL_FIXED: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == CTL_ADDR) |=> reg_rdata[FIX_LSB +: 2] == 2'b11); // R1
  AST_RECORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (hit && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1) && vb); // R4
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (hit && ptr == LAST) |=> (!en && ptr == '0 && irq)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !cwr) |=> ($stable(ptr) && $stable(vb))); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !cwr) |=> irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cwr |=> !irq); // R7
endmodule

bind brsamp_buf brsamp_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .br_valid(br_valid), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq(irq), .ctl_word(ctl_word)
);

// File: tb/brsamp_buf_tb.sv
module brsamp_buf_tb_top;
  localparam int DEPTH = 16;
  localparam int AW = 6;
  localparam logic [63:0] MARK = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [AW-1:0] CTL = 6'd32;

  logic clk = 0, rst = 1;
  logic br_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [63:0] br_from = 0, br_to = 0, reg_wdata = 0;
  logic [AW-1:0] reg_addr = 0;
  logic [63:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;

  // reference model
  logic [63:0] m_from [DEPTH];
  logic [63:0] m_to [DEPTH];
  logic m_en = 0, m_vb = 0, m_irq = 0;
  logic [3:0] m_ptr = 0;
  logic [2:0] m_sel = 0;

  logic [63:0] exp_q[$];
  string tag_q[$];
  logic rd_fire = 0;
  bit done = 0;

  always #5 clk = ~clk;

  brsamp_buf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [63:0] m_ctl();
    logic [63:0] w = 64'h18;
    w[2] = m_en; w[5] = m_vb; w[19:16] = m_ptr; w[26:24] = m_sel;
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; model follows the requirement rules (R4 R5 R6 R10)
  task automatic step(input logic bv, input logic [63:0] f, input logic [63:0] t,
                      input logic wr, input logic [AW-1:0] a, input logic [63:0] wd);
    logic rec, cw;
    br_valid = bv; br_from = f; br_to = t; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    cw  = wr && (a == CTL);
    rec = bv && m_en && !cw;
    @(negedge clk);
    br_valid = 0; reg_wr = 0;
    if (cw) begin
      m_en = wd[2]; m_vb = wd[5]; m_ptr = wd[19:16]; m_sel = wd[26:24]; m_irq = 0;
    end else if (rec) begin
      m_from[m_ptr] = f; m_to[m_ptr] = t; m_vb = 1;
      if (m_ptr == 4'd15) begin m_ptr = 0; m_en = 0; m_irq = 1; end
      else m_ptr = m_ptr + 1;
    end
    if (wr && !a[5] && !rec) begin
      if (a[0]) m_to[a[4:1]] = wd; else m_from[a[4:1]] = wd;
    end
  endtask

  // driver: pushes expected read data to the scoreboard
  task automatic rd(input logic [AW-1:0] a, input string req);
    reg_rd = 1; reg_addr = a;
    if (a == CTL) exp_q.push_back(m_ctl());
    else if (a[0]) exp_q.push_back(m_to[a[4:1]]);
    else exp_q.push_back(m_from[a[4:1]]);
    tag_q.push_back(req);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic irq_chk(input string req);
    check(req, {63'b0, irq}, {63'b0, m_irq});
  endtask

  // monitor
  always @(posedge clk) rd_fire <= reg_rd;
  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(CTL, "R1 reset control word");
    irq_chk("R1 reset irq");

    // marker write into slot 3 destination, plain write to slot 3 source
    step(0, 0, 0, 1, 6'd7, MARK);
    step(0, 0, 0, 1, 6'd6, 64'h1234_5678_9ABC_DEF0);
    rd(6'd7, "R8 marker stored");
    rd(6'd6, "R8 entry write");

    // enable with counter select 5
    step(0, 0, 0, 1, CTL, 64'h0500_0004);
    rd(CTL, "R2 control fields");
    for (int i = 0; i < 3; i++) step(1, 64'h1000 + i, 64'h2000 + i, 0, 0, 0);
    rd(CTL, "R4 pointer advance and valid");
    for (int i = 0; i < 3; i++) begin
      rd(6'(2 * i), "R3 source slot");
      rd(6'(2 * i + 1), "R3 destination slot");
    end

    // clear only enable (read-modify-write), then strobe while disabled
    step(0, 0, 0, 1, CTL, m_ctl() & ~64'h4);
    rd(CTL, "R9 enable clear keeps pointer and valid");
    step(1, 64'hDEAD, 64'hBEEF, 0, 0, 0);
    rd(CTL, "R6 disabled strobe leaves control");
    rd(6'd7, "R6 disabled strobe leaves entry");
    irq_chk("R6 no irq");

    // zero write resets pointer and valid
    step(0, 0, 0, 1, CTL, 64'h0);
    rd(CTL, "R9 zero write");

    // collision: control write and branch together
    step(0, 0, 0, 1, CTL, 64'h4);
    step(1, 64'hAAAA, 64'hBBBB, 1, CTL, 64'h0000_0000_0003_0004);
    rd(CTL, "R10 control write wins");
    // collision: entry write and recorded branch together
    step(1, 64'h5555, 64'h6666, 1, 6'd1, 64'h7777);
    rd(6'd7, "R10 branch stored over entry write");
    rd(6'd6, "R10 branch source stored");
    rd(6'd1, "R10 entry write dropped");

    // fill from pointer 0 to the end
    step(0, 0, 0, 1, CTL, 64'h4);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) irq_chk("R5 irq low before last slot");
      step(1, 64'hF000 + i, 64'hE000 + i, 0, 0, 0);
    end
    irq_chk("R5 irq on full");
    rd(CTL, "R5 enable cleared, pointer wrapped");
    rd(6'd30, "R5 last source");
    rd(6'd31, "R5 last destination");
    step(1, 64'h9999, 64'h8888, 0, 0, 0);
    rd(6'd0, "R6 saturated buffer keeps slot 0");
    rd(CTL, "R6 saturated control unchanged");
    repeat (4) @(negedge clk);
    irq_chk("R7 irq held");
    step(0, 0, 0, 1, CTL, m_ctl());
    irq_chk("R7 irq cleared by control write");
    rd(CTL, "R2 written back fields");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule